// File: doc/BRIEF.md
# Accelerator Unit Power Sequencer

This block controls the power state of a bank of accelerator units. Each unit has its own 32-bit control and status word. Software sets a single request bit to power a unit down, and clears it to bring the unit back up. The block then runs a handshake with the unit. It raises a power-down command and waits for the unit's acknowledgement. When waking, it drops the command and waits, with no time limit, until the unit reports that power-up and any built-in self-test have finished. Two read-only flags in the same word show when the unit is fully off and when it is running.

The units are placed on a 4-byte stride, and a parameter mask sets which of them exist. Every unit runs its own four-state machine: active, going down, off and waking. The request bit is held in a register, so a request written while a transition is running takes effect only once that transition has finished. Reads are combinational from the address port.

Top module: `accel_pwr_seq`

## Requirements
- R1: The word for unit n is at byte address 4*n. The upper address bits addr[ADDR_W-1:2] pick the unit and addr[1:0] are ignored.
- R2: A write sets the request bit (bit 0) from wdata[0], where 1 asks for power-down and 0 asks for activation. The new value reads back right after the write edge.
- R3: Bit 27 (off flag) is 1 only while the unit is off. Bit 29 (active flag) is 1 only while the unit is running. The two flags are never 1 together.
- R4: During and after reset, every implemented unit has its request bit at 1, its off flag at 1, its active flag at 0 and its unit_pd_cmd output at 1.
- R5: In the running state with the request at 1, the next edge starts power-down: unit_pd_cmd goes to 1 and both flags read 0. The unit stays in this state until unit_pd_ack is sampled high, and the off flag reads 1 after that edge.
- R6: In the off state with the request at 0, the next edge starts wake-up: unit_pd_cmd goes to 0 and both flags read 0. The unit stays in this state for any number of cycles until unit_up_done is sampled high, and the active flag reads 1 after that edge.
- R7: A request written while a transition is running does not cut that transition short. It is acted on at the first edge after the transition completes.
- R8: Writes to any bit other than bit 0 have no effect. All bits other than 0, 27 and 29 always read 0.
- R9: Unit slots outside the mask, and addresses beyond NUM_UNITS, read 0 and ignore writes. Their unit_pd_cmd stays 0.
- R10: unit_pd_ack has no effect unless its unit is going down, and unit_up_done has no effect unless its unit is waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Byte address of the word to write or read |
| wdata | input | 32 | Write data (only bit 0 is used) |
| rdata | output | 32 | Combinational read data of the addressed word |
| unit_pd_ack | input | NUM_UNITS | Unit reports that power-down is complete |
| unit_up_done | input | NUM_UNITS | Unit reports that power-up and self-test are complete |
| unit_pd_cmd | output | NUM_UNITS | Power-down command to each unit, low while waking or running |

## Verification
A unit whose state register is wrong shows up at once in two places. The flags in its word would disagree with its unit_pd_cmd pin, and the bench compares both on the cycle after every edge. A request register that was lost or not latched would show as a transition that starts one edge too early or never starts at all. For that reason the bench checks the word on each edge around an acknowledgement and around a write made during a transition. A missing wait would let the active flag appear before unit_up_done, and a wake-up held for a thousand cycles exposes that.

// File: rtl/accel_pwr_pkg.sv
// Shared definitions for the accelerator power sequencer.
// Assumes 32-bit register words; bit positions are fixed by the register layout.
package accel_pwr_pkg;
    localparam int REQ_BIT = 0;   // power-down request, writable
    localparam int OFF_BIT = 27;  // unit fully off, read-only
    localparam int ON_BIT  = 29;  // unit running, read-only

    typedef enum logic [1:0] {
        PS_ACTIVE     = 2'd0,
        PS_GOING_DOWN = 2'd1,
        PS_OFF        = 2'd2,
        PS_WAKING     = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/accel_pwr_unit.sv
// Per-unit power handshake: one request register and a four-state machine.
// Assumes the acknowledge inputs are synchronous to clk. Wake-up has no time
// limit, so the self-test may take as long as the unit needs.
module accel_pwr_unit
    import accel_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_val,
    input  logic pd_ack,
    input  logic up_done,
    output logic req_q,
    output logic pd_cmd,
    output logic flag_off,
    output logic flag_on
);
    pwr_state_e state_q, state_d;

    // Request register: holds the last value software wrote to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= 1'b1;
        else if (wr_hit) req_q <= wr_val;
    end

    // Next state: a transition is left only on its own completion input.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_ACTIVE:     if (req_q)   state_d = PS_GOING_DOWN;
            PS_GOING_DOWN: if (pd_ack)  state_d = PS_OFF;
            PS_OFF:        if (!req_q)  state_d = PS_WAKING;
            PS_WAKING:     if (up_done) state_d = PS_ACTIVE;
            default:                    state_d = PS_OFF;
        endcase
    end

    // State register: reset leaves the unit off.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    // Outputs decoded from state.
    always_comb begin
        pd_cmd   = (state_q == PS_GOING_DOWN) || (state_q == PS_OFF);
        flag_off = (state_q == PS_OFF);
        flag_on  = (state_q == PS_ACTIVE);
    end

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_off && flag_on));

    a_r4_reset_off: assert property (@(posedge clk)
        !rst_n |=> (flag_off && req_q && pd_cmd));

    a_r5_ack_lands_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_cmd && !flag_off && pd_ack) |=> flag_off);

    a_r6_wake_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_cmd && !flag_on && !up_done) |=> (!flag_on && !pd_cmd));

    a_r10_off_exit_only_wake: assert property (@(posedge clk) disable iff (!rst_n)
        flag_off |=> (flag_off || !pd_cmd));

    a_r7_running_req_starts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_on && req_q) |=> (pd_cmd && !flag_off));
endmodule

// File: rtl/accel_pwr_rdmux.sv
// Read multiplexer: assembles the addressed unit's word from its request bit
// and flags. Any slot index that has no unit returns zero.
module accel_pwr_rdmux
    import accel_pwr_pkg::*;
#(
    parameter int NUM_UNITS = 16,
    parameter int IDX_W     = 6
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_UNITS-1:0] req,
    input  logic [NUM_UNITS-1:0] off,
    input  logic [NUM_UNITS-1:0] on,
    output logic [31:0]          rdata
);
    // Select the matching unit's word; slots without a unit read as zero.
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_UNITS; n++) begin
            if (idx == IDX_W'(n)) begin
                rdata[REQ_BIT] = req[n];
                rdata[OFF_BIT] = off[n];
                rdata[ON_BIT]  = on[n];
            end
        end
    end
endmodule

// File: rtl/accel_pwr_seq.sv
// Top of the accelerator power sequencer: decodes the address, keeps one
// handshake machine per implemented unit and muxes the read word.
// Assumes NUM_UNITS <= 2**(ADDR_W-2) and NUM_UNITS <= 32.
module accel_pwr_seq #(
    parameter int                    NUM_UNITS = 16,
    parameter int                    ADDR_W    = 8,
    parameter logic [NUM_UNITS-1:0]  UNIT_MASK = 16'h1FFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_UNITS-1:0] unit_pd_ack,
    input  logic [NUM_UNITS-1:0] unit_up_done,
    output logic [NUM_UNITS-1:0] unit_pd_cmd
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]     idx;
    logic [NUM_UNITS-1:0] wr_sel;
    logic [NUM_UNITS-1:0] req_v, off_v, on_v;

    // Word index: the byte offset within a word is dropped.
    assign idx = addr[ADDR_W-1:2];

    // Write select: one strobe per unit slot.
    always_comb begin
        for (int n = 0; n < NUM_UNITS; n++)
            wr_sel[n] = wr_en && (idx == IDX_W'(n));
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        if (UNIT_MASK[g]) begin : g_impl
            accel_pwr_unit u_unit (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_hit   (wr_sel[g]),
                .wr_val   (wdata[accel_pwr_pkg::REQ_BIT]),
                .pd_ack   (unit_pd_ack[g]),
                .up_done  (unit_up_done[g]),
                .req_q    (req_v[g]),
                .pd_cmd   (unit_pd_cmd[g]),
                .flag_off (off_v[g]),
                .flag_on  (on_v[g])
            );
        end else begin : g_absent
            assign req_v[g]       = 1'b0;
            assign off_v[g]       = 1'b0;
            assign on_v[g]        = 1'b0;
            assign unit_pd_cmd[g] = 1'b0;
        end
    end

    accel_pwr_rdmux #(
        .NUM_UNITS (NUM_UNITS),
        .IDX_W     (IDX_W)
    ) u_rdmux (
        .idx   (idx),
        .req   (req_v),
        .off   (off_v),
        .on    (on_v),
        .rdata (rdata)
    );

    a_r9_absent_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_pd_cmd & ~UNIT_MASK) == '0);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~32'h2800_0001) == 32'h0);
endmodule

// File: tb/accel_pwr_seq_test.sv
module accel_pwr_seq_test;
    localparam int N = 16;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [15:0] ack;
        logic [15:0] done;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic [15:0] exp_cmd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        // R2: clear request of unit 0, still off this edge
        '{1'b1, 8'h00, 32'h0,         16'h0,    16'h0,    8'h00, 32'h0800_0000, 16'h1FFF, 8'd2},
        // R6: wake starts
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0,    8'h00, 32'h0000_0000, 16'h1FFE, 8'd6},
        // R6: wake holds without done
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0,    8'h00, 32'h0000_0000, 16'h1FFE, 8'd6},
        // R6: done lands active
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0001, 8'h00, 32'h2000_0000, 16'h1FFE, 8'd6},
        // R10: done to an off unit is ignored
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0002, 8'h04, 32'h0800_0001, 16'h1FFE, 8'd10},
        // R8: other bits written ignored
        '{1'b1, 8'h00, 32'hFFFF_FFFE, 16'h0,    16'h0,    8'h00, 32'h2000_0000, 16'h1FFE, 8'd8},
        // R2: request power-down
        '{1'b1, 8'h00, 32'h1,         16'h0,    16'h0,    8'h00, 32'h2000_0001, 16'h1FFE, 8'd2},
        // R5: going down
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0,    8'h00, 32'h0000_0001, 16'h1FFF, 8'd5},
        // R7: ack plus wake request during transition
        '{1'b1, 8'h00, 32'h0,         16'h0001, 16'h0,    8'h00, 32'h0800_0000, 16'h1FFF, 8'd7},
        // R7: latched request acted on
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0,    8'h00, 32'h0000_0000, 16'h1FFE, 8'd7},
        // R7: down request during wake
        '{1'b1, 8'h00, 32'h1,         16'h0,    16'h0,    8'h00, 32'h0000_0001, 16'h1FFE, 8'd7},
        // R7: wake completes first
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0001, 8'h00, 32'h2000_0001, 16'h1FFE, 8'd7},
        // R7: then goes down
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0,    8'h00, 32'h0000_0001, 16'h1FFF, 8'd7},
        // R5: ack lands off
        '{1'b0, 8'h00, 32'h0,         16'h0001, 16'h0,    8'h00, 32'h0800_0001, 16'h1FFF, 8'd5},
        // R9: absent slot 13
        '{1'b1, 8'h34, 32'h0,         16'h0,    16'h0,    8'h34, 32'h0000_0000, 16'h1FFF, 8'd9},
        // R1: byte offset ignored, unit 3
        '{1'b1, 8'h0E, 32'h0,         16'h0,    16'h0,    8'h0C, 32'h0800_0000, 16'h1FFF, 8'd1},
        // R1: read unit 3 at offset 1
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0,    8'h0D, 32'h0000_0000, 16'h1FF7, 8'd1},
        // R10: done to all, only unit 3 moves
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'hFFFF, 8'h0C, 32'h2000_0000, 16'h1FF7, 8'd10},
        // R9: beyond NUM_UNITS
        '{1'b0, 8'h00, 32'h0,         16'h0,    16'h0,    8'hFC, 32'h0000_0000, 16'h1FF7, 8'd9},
        // R10: ack to running unit ignored
        '{1'b0, 8'h00, 32'h0,         16'hFFFF, 16'h0,    8'h0C, 32'h2000_0000, 16'h1FF7, 8'd10}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  unit_pd_ack = '0;
    logic [N-1:0]  unit_up_done = '0;
    logic [N-1:0]  unit_pd_cmd;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    accel_pwr_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .unit_pd_ack  (unit_pd_ack),
        .unit_up_done (unit_up_done),
        .unit_pd_cmd  (unit_pd_cmd)
    );

    task automatic check(input int req, input logic [7:0] ra,
                         input logic [31:0] exp_rd, input logic [15:0] exp_cmd);
        addr = ra;
        #1;
        checks++;
        if (rdata !== exp_rd || unit_pd_cmd !== exp_cmd) begin
            errors++;
            $display("FAIL R%0d: addr %h rdata %h cmd %h, expected rdata %h cmd %h",
                     req, ra, rdata, unit_pd_cmd, exp_rd, exp_cmd);
        end
    endtask

    // One cycle: drive at falling edge, clear after the rising edge, then check.
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [15:0] ack, input logic [15:0] dn);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; unit_pd_ack = ack; unit_up_done = dn;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0; unit_pd_ack = '0; unit_up_done = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        // R4: reset state of implemented unit while reset held
        check(4, 8'h00, 32'h0800_0001, 16'h1FFF);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #0.5;
        // R4: reset state after release
        check(4, 8'h30, 32'h0800_0001, 16'h1FFF);
        // R3: every implemented unit has only the off flag
        for (int u = 0; u < 13; u++) check(3, 8'(u * 4), 32'h0800_0001, 16'h1FFF);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].ack, VEC[i].done);
            check(int'(VEC[i].req), VEC[i].raddr, VEC[i].exp_rd, VEC[i].exp_cmd);
        end

        // R6: long self-test, unit 5 waits 1000 cycles
        step(1'b1, 8'h14, 32'h0, 16'h0, 16'h0);
        for (int c = 0; c < 1000; c++) step(1'b0, 8'h00, 32'h0, 16'h0, 16'h0);
        check(6, 8'h14, 32'h0000_0000, 16'h1FD7);
        step(1'b0, 8'h00, 32'h0, 16'h0, 16'h0020);
        check(6, 8'h14, 32'h2000_0000, 16'h1FD7);

        // R5: power-down waits for ack over many cycles
        step(1'b1, 8'h14, 32'h1, 16'h0, 16'h0);
        for (int c = 0; c < 50; c++) step(1'b0, 8'h00, 32'h0, 16'h0, 16'h0);
        check(5, 8'h14, 32'h0000_0001, 16'h1FF7);

        // R4: mid-run reset returns every unit to off
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        check(4, 8'h0C, 32'h0800_0001, 16'h1FFF);
        check(4, 8'h14, 32'h0800_0001, 16'h1FFF);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule